// File: doc/BRIEF.md
# Flash Command Decoder

This block sits between the host write path of a NOR-style flash and its program/erase engine. Every host write strobe carries an address and a data word. The block reads the low data byte as a command or as a sequence argument. From that it keeps the current read-mode select, which steers the read mux to one of four sources: the array, the identifier table, the query table or the status word. It also issues one-cycle operation requests, with their address and data, to the engine that carries the work out.

Every erase, lock and program operation takes two write cycles: first a setup opcode, then a second cycle. That second cycle is either a confirm code or the data to program. When an operation starts, or when a sequence is rejected, the read mode moves to status on its own, so the host can poll completion. A buffered write is longer:

- a setup cycle,
- a word count,
- count+1 data cycles, each handed to the engine at once,
- a final confirm.

The identifier and lock commands are refused while the engine reports busy. Array contents, table contents and operation timing are kept outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and while `pwr_down` is high, the read mode is array (code 0), no pulse output is high, and any partly entered sequence is dropped. A write of FFh selects array mode.
- R2: With no sequence open, 90h selects identifier mode (code 1), 98h selects query mode (code 2) and 70h selects status mode (code 3). Any other low byte that is not a setup opcode leaves the mode unchanged and starts nothing. Read-mode codes are 0 array, 1 identifier, 2 query, 3 status.
- R3: A write of 50h raises `clr_status` for exactly one cycle and leaves the read mode unchanged.
- R4: A write of 40h or 10h, followed by any write, raises `op_valid` with `op_kind`=1. `op_addr` and `op_data` take the second write's address and full data word.
- R5: 20h followed by D0h raises `op_valid` with `op_kind`=2 and `op_addr` equal to the confirm write's address.
- R6: 60h followed by 01h raises `op_valid` with `op_kind`=3 (set lock), with the 01h write's address. 60h followed by D0h gives `op_kind`=4 (clear all locks).
- R7: After an erase or lock setup, any second byte other than its confirm code raises `seq_err` for one cycle and starts no operation. A buffered write whose final byte is not D0h is treated the same way. The sequence then closes.
- R8: An operation start or a sequence error puts the read mode into status. Writes that are not read-mode commands leave it there until a read-mode command arrives.
- R9: While `eng_busy` is high, 90h and the 60h lock setup are ignored. A following 01h or D0h then starts nothing. Other commands are still accepted.
- R10: Command and argument decoding uses only data bits 7:0. Bits 15:8 have no effect except as program or buffer data.
- R11: E8h selects status mode and latches its address. The next low byte is the count N. The next N+1 writes each raise `buf_wr` with that write's address and data. A final D0h raises `op_valid` with `op_kind`=5, the latched address and `op_data`=N.
- R12: A buffered-write count N of BUF_WORDS or more raises `seq_err` and closes the sequence without any `buf_wr`.
- R13: `page_ok` is high exactly when the read mode is array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down; holds the block in its reset state |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | AW | Address of the host write |
| wr_data | input | DW | Data of the host write |
| eng_busy | input | 1 | Program/erase engine is running |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| page_ok | output | 1 | Page-mode reads allowed |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 1 program, 2 erase, 3 set lock, 4 clear locks, 5 buffered write |
| op_addr | output | AW | Address for the request or buffer word |
| op_data | output | DW | Data for the request or buffer word |
| buf_wr | output | 1 | One-cycle buffer data handoff |
| seq_err | output | 1 | One-cycle sequence error (sets both error bits) |
| clr_status | output | 1 | One-cycle clear-status request |

## Verification
The hardest states to reach are deep inside a buffered write. These are the last data cycle for each count value, a wrong confirm after the data, and an out-of-range count. Getting there needs an exact chain of setup, count and data writes. The bench builds that chain for every legal count from 0 to BUF_WORDS-1, checks every handoff pulse on the way, and then sends a wrong final byte and an illegal count. A second hard case is a confirm byte that arrives after a lock setup was refused under busy. The bench raises busy just before the setup, then checks that the stray confirm starts nothing.

// File: rtl/fcmd_pkg.sv
// Package: shared opcode values and type encodings for the flash command
// decoder. Assumes commands are carried in the low data byte.
package fcmd_pkg;

    localparam logic [7:0] OPC_ARRAY     = 8'hFF;
    localparam logic [7:0] OPC_IDENT     = 8'h90;
    localparam logic [7:0] OPC_QUERY     = 8'h98;
    localparam logic [7:0] OPC_STATUS    = 8'h70;
    localparam logic [7:0] OPC_CLEAR     = 8'h50;
    localparam logic [7:0] OPC_PROG_A    = 8'h40;
    localparam logic [7:0] OPC_PROG_B    = 8'h10;
    localparam logic [7:0] OPC_ERASE     = 8'h20;
    localparam logic [7:0] OPC_LOCK      = 8'h60;
    localparam logic [7:0] OPC_BUFFER    = 8'hE8;
    localparam logic [7:0] OPC_CONFIRM   = 8'hD0;
    localparam logic [7:0] OPC_LOCK_SET  = 8'h01;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PROG     = 3'd1,
        OP_ERASE    = 3'd2,
        OP_LOCK_SET = 3'd3,
        OP_LOCK_CLR = 3'd4,
        OP_BUF      = 3'd5
    } opkind_t;

    typedef enum logic [3:0] {
        CMD_ARRAY, CMD_IDENT, CMD_QUERY, CMD_STATUS, CMD_CLEAR,
        CMD_PROG, CMD_ERASE, CMD_LOCK, CMD_BUFFER, CMD_CONFIRM,
        CMD_LOCK_SET, CMD_OTHER
    } cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PROG, SQ_ERASE, SQ_LOCK, SQ_BCOUNT, SQ_BDATA, SQ_BCONF
    } seq_t;

endpackage

// File: rtl/fcmd_classify.sv
// Module: fcmd_classify
// Maps a command byte to a command class. Purely combinational; the caller
// supplies only the low data byte, so upper data bits can never matter.
module fcmd_classify
    import fcmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_t       cls
);

    // Opcode lookup.
    always_comb begin
        case (code)
            OPC_ARRAY:    cls = CMD_ARRAY;
            OPC_IDENT:    cls = CMD_IDENT;
            OPC_QUERY:    cls = CMD_QUERY;
            OPC_STATUS:   cls = CMD_STATUS;
            OPC_CLEAR:    cls = CMD_CLEAR;
            OPC_PROG_A,
            OPC_PROG_B:   cls = CMD_PROG;
            OPC_ERASE:    cls = CMD_ERASE;
            OPC_LOCK:     cls = CMD_LOCK;
            OPC_BUFFER:   cls = CMD_BUFFER;
            OPC_CONFIRM:  cls = CMD_CONFIRM;
            OPC_LOCK_SET: cls = CMD_LOCK_SET;
            default:      cls = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/fcmd_tally.sv
// Module: fcmd_tally
// Counts down the remaining buffered-write data cycles. 'last' is high when
// the next data cycle is the final one. Assumes load and dec never coincide.
module fcmd_tally #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);

    logic [CW-1:0] remain;

    // Remaining-word register.
    always_ff @(posedge clk) begin
        if (!rst_n)    remain <= '0;
        else if (load) remain <= load_val;
        else if (dec)  remain <= remain - 1'b1;
    end

    assign last = (remain == '0);

endmodule

// File: rtl/fcmd_seq.sv
// Module: fcmd_seq
// Command sequencer: holds the read mode and the open multi-cycle sequence,
// and emits registered one-cycle request pulses. Assumes wr_en is one cycle
// per host write and pwr_down acts like a synchronous reset.
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16,
    parameter int BUF_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          wr_en,
    input  cmd_t          cls,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          cnt_last,
    output logic          cnt_load,
    output logic          cnt_dec,
    output rmode_t        mode,
    output logic          op_valid,
    output opkind_t       op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          buf_wr,
    output logic          seq_err,
    output logic          clr_status
);

    seq_t          state;
    logic [AW-1:0] base_addr;
    logic [7:0]    buf_n;
    logic          count_ok;

    assign count_ok = (int'(wr_data[7:0]) < BUF_WORDS);

    // Counter strobes: load on a good count, step on each buffer data cycle.
    always_comb begin
        cnt_load = wr_en && !pwr_down && (state == SQ_BCOUNT) && count_ok;
        cnt_dec  = wr_en && !pwr_down && (state == SQ_BDATA);
    end

    // Sequence state, read mode and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            state      <= SQ_IDLE;
            mode       <= RM_ARRAY;
            op_valid   <= 1'b0;
            op_kind    <= OP_NONE;
            op_addr    <= '0;
            op_data    <= '0;
            buf_wr     <= 1'b0;
            seq_err    <= 1'b0;
            clr_status <= 1'b0;
            base_addr  <= '0;
            buf_n      <= '0;
        end else begin
            op_valid   <= 1'b0;
            buf_wr     <= 1'b0;
            seq_err    <= 1'b0;
            clr_status <= 1'b0;
            if (wr_en) begin
                case (state)
                    SQ_IDLE: begin
                        case (cls)
                            CMD_ARRAY:  mode <= RM_ARRAY;
                            CMD_IDENT:  if (!busy) mode <= RM_IDENT;
                            CMD_QUERY:  mode <= RM_QUERY;
                            CMD_STATUS: mode <= RM_STATUS;
                            CMD_CLEAR:  clr_status <= 1'b1;
                            CMD_PROG:   state <= SQ_PROG;
                            CMD_ERASE:  state <= SQ_ERASE;
                            CMD_LOCK:   if (!busy) state <= SQ_LOCK;
                            CMD_BUFFER: begin
                                state     <= SQ_BCOUNT;
                                mode      <= RM_STATUS;
                                base_addr <= wr_addr;
                            end
                            default: ;
                        endcase
                    end
                    SQ_PROG: begin
                        op_valid <= 1'b1;
                        op_kind  <= OP_PROG;
                        op_addr  <= wr_addr;
                        op_data  <= wr_data;
                        mode     <= RM_STATUS;
                        state    <= SQ_IDLE;
                    end
                    SQ_ERASE: begin
                        if (cls == CMD_CONFIRM) begin
                            op_valid <= 1'b1;
                            op_kind  <= OP_ERASE;
                            op_addr  <= wr_addr;
                            op_data  <= '0;
                        end else begin
                            seq_err <= 1'b1;
                        end
                        mode  <= RM_STATUS;
                        state <= SQ_IDLE;
                    end
                    SQ_LOCK: begin
                        if (cls == CMD_LOCK_SET) begin
                            op_valid <= 1'b1;
                            op_kind  <= OP_LOCK_SET;
                            op_addr  <= wr_addr;
                            op_data  <= '0;
                        end else if (cls == CMD_CONFIRM) begin
                            op_valid <= 1'b1;
                            op_kind  <= OP_LOCK_CLR;
                            op_addr  <= wr_addr;
                            op_data  <= '0;
                        end else begin
                            seq_err <= 1'b1;
                        end
                        mode  <= RM_STATUS;
                        state <= SQ_IDLE;
                    end
                    SQ_BCOUNT: begin
                        if (count_ok) begin
                            buf_n <= wr_data[7:0];
                            state <= SQ_BDATA;
                        end else begin
                            seq_err <= 1'b1;
                            state   <= SQ_IDLE;
                        end
                    end
                    SQ_BDATA: begin
                        buf_wr  <= 1'b1;
                        op_addr <= wr_addr;
                        op_data <= wr_data;
                        if (cnt_last) state <= SQ_BCONF;
                    end
                    SQ_BCONF: begin
                        if (cls == CMD_CONFIRM) begin
                            op_valid <= 1'b1;
                            op_kind  <= OP_BUF;
                            op_addr  <= base_addr;
                            op_data  <= {{(DW-8){1'b0}}, buf_n};
                        end else begin
                            seq_err <= 1'b1;
                        end
                        mode  <= RM_STATUS;
                        state <= SQ_IDLE;
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Module: flash_cmd_decoder (top)
// Turns host write cycles into a read-mode select and engine requests.
// Assumes one wr_en pulse per bus write and DW of at least 8.
module flash_cmd_decoder
    import fcmd_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16,
    parameter int BUF_WORDS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          eng_busy,
    output logic [1:0]    rd_mode,
    output logic          page_ok,
    output logic          op_valid,
    output logic [2:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          buf_wr,
    output logic          seq_err,
    output logic          clr_status
);

    localparam int CW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

    cmd_t    cls;
    rmode_t  mode;
    opkind_t kind;
    logic    cnt_load, cnt_dec, cnt_last;

    fcmd_classify u_cls (
        .code (wr_data[7:0]),
        .cls  (cls)
    );

    fcmd_tally #(.CW(CW)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (wr_data[CW-1:0]),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    fcmd_seq #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .wr_en      (wr_en),
        .cls        (cls),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (eng_busy),
        .cnt_last   (cnt_last),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .mode       (mode),
        .op_valid   (op_valid),
        .op_kind    (kind),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .buf_wr     (buf_wr),
        .seq_err    (seq_err),
        .clr_status (clr_status)
    );

    // Plain-vector views of the enum outputs.
    assign rd_mode = mode;
    assign op_kind = kind;
    assign page_ok = (mode == RM_ARRAY);

endmodule

// File: rtl/flash_cmd_decoder_checker.sv
// Module: flash_cmd_decoder_checker
// Temporal checks on the decoder ports; attached by bind below.
module flash_cmd_decoder_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_down,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          eng_busy,
    input logic [1:0]    rd_mode,
    input logic          op_valid,
    input logic          seq_err,
    input logic          buf_wr,
    input logic          clr_status
);

    a_r1_powerdown_array: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (rd_mode == 2'd0 && !op_valid && !seq_err && !buf_wr && !clr_status));

    a_r2_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$past(pwr_down)) |-> $stable(rd_mode));

    a_r3_clear_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |-> $stable(rd_mode));

    a_r4_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || seq_err || buf_wr || clr_status) |-> $past(wr_en));

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_valid, seq_err, buf_wr, clr_status}));

    a_r8_start_status: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || seq_err) |-> rd_mode == 2'd3);

    a_r9_ident_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd1 && $past(rd_mode) != 2'd1) |-> !$past(eng_busy));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_checker #(.DW(DW)) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

    localparam int AW = 23;
    localparam int DW = 16;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_down = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_busy = 1'b0;
    logic [1:0]    rd_mode;
    logic          page_ok, op_valid, buf_wr, seq_err, clr_status;
    logic [2:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    flash_cmd_decoder #(.AW(AW), .DW(DW), .BUF_WORDS(BW)) uut (.*);

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_pulses(input string req);
        check(req, {op_valid, seq_err, buf_wr, clr_status}, 4'b0000);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset mode", rd_mode, 0);
        check("R13 reset page", page_ok, 1);
        idle_pulses("R1 reset pulses");

        // R2 R3 R10 R13: sweep single-cycle codes, with junk in the upper byte
        for (int c = 0; c < 256; c++) begin
            logic [1:0] em;
            if (c == 8'h40 || c == 8'h10 || c == 8'h20 || c == 8'h60 || c == 8'hE8) continue;
            wr(23'h1, 16'h00FF);
            check("R1 FF array", rd_mode, 0);
            em = (c == 8'h90) ? 2'd1 : (c == 8'h98) ? 2'd2 : (c == 8'h70) ? 2'd3 : 2'd0;
            wr(23'(c), {8'(c ^ 8'h5A), 8'(c)});
            check("R2 R10 mode", rd_mode, em);
            check("R13 page", page_ok, em == 2'd0);
            check("R3 clr pulse", clr_status, c == 8'h50);
            check("R2 no op", {op_valid, seq_err, buf_wr}, 3'b000);
            if (c == 8'h50) begin
                @(negedge clk);
                check("R3 clr one cycle", clr_status, 0);
            end
        end

        // R4 program with both opcodes
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] d;
                logic [22:0] a;
                d = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h1234 : 16'h00D0;
                a = 23'h100 * (k + 1) + 23'(p);
                wr(23'h0, p ? 16'h7710 : 16'h0040);
                check("R4 setup quiet", op_valid, 0);
                wr(a, d);
                check("R4 op", {op_valid, op_kind}, {1'b1, 3'd1});
                check("R4 addr", op_addr, a);
                check("R4 data", op_data, d);
                check("R8 status", rd_mode, 3);
            end
        end
        wr(23'h0, 16'h0033);
        check("R8 stays status", rd_mode, 3);
        wr(23'h0, 16'h00FF);
        check("R8 leaves on FF", rd_mode, 0);

        // R5 erase, R10 upper byte ignored
        wr(23'h020000, 16'hAB20);
        wr(23'h020044, 16'h55D0);
        check("R5 erase op", {op_valid, op_kind}, {1'b1, 3'd2});
        check("R5 erase addr", op_addr, 23'h020044);
        // R7 wrong erase confirm; FF is consumed as the bad confirm
        wr(23'h0, 16'h00FF);
        wr(23'h0, 16'h0020);
        wr(23'h0, 16'h00FF);
        check("R7 erase err", {op_valid, seq_err}, 2'b01);
        check("R7 R8 status", rd_mode, 3);

        // R6 locks
        wr(23'h030000, 16'h0060);
        wr(23'h030008, 16'h0001);
        check("R6 set lock", {op_valid, op_kind}, {1'b1, 3'd3});
        check("R6 set addr", op_addr, 23'h030008);
        wr(23'h0, 16'h0060);
        wr(23'h5, 16'h00D0);
        check("R6 clear locks", {op_valid, op_kind}, {1'b1, 3'd4});
        wr(23'h0, 16'h0060);
        wr(23'h0, 16'h0002);
        check("R7 lock err", {op_valid, seq_err}, 2'b01);
        @(negedge clk);
        check("R7 err one cycle", seq_err, 0);

        // R9 busy refusal
        wr(23'h0, 16'h0098);
        eng_busy = 1'b1;
        wr(23'h0, 16'h0090);
        check("R9 ident refused", rd_mode, 2);
        wr(23'h0, 16'h0060);
        wr(23'h0, 16'h0001);
        idle_pulses("R9 lock refused");
        wr(23'h0, 16'h0060);
        wr(23'h0, 16'h00D0);
        idle_pulses("R9 clear refused");
        check("R9 mode kept", rd_mode, 2);
        wr(23'h0, 16'h0070);
        check("R9 status ok busy", rd_mode, 3);
        eng_busy = 1'b0;
        wr(23'h0, 16'h0090);
        check("R9 ident idle", rd_mode, 1);

        // R1 power-down drops an open sequence
        wr(23'h0, 16'h0020);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        check("R1 pd mode", rd_mode, 0);
        wr(23'h0, 16'h00D0);
        idle_pulses("R1 pd dropped");

        // R11 buffered write for every legal count
        for (int n = 0; n < BW; n++) begin
            logic [22:0] base;
            base = 23'h040000 + 23'(n * 64);
            wr(base, 16'h00E8);
            check("R11 setup status", rd_mode, 3);
            wr(base, {8'hC3, 8'(n)});
            idle_pulses("R11 count quiet");
            for (int i = 0; i <= n; i++) begin
                wr(base + 23'(i), 16'hA000 + 16'(n * 16 + i));
                check("R11 buf pulse", {buf_wr, op_valid}, 2'b10);
                check("R11 buf addr", op_addr, base + 23'(i));
                check("R11 buf data", op_data, 16'hA000 + 16'(n * 16 + i));
            end
            wr(base + 23'h3, 16'h00D0);
            check("R11 buf op", {op_valid, op_kind, buf_wr}, {1'b1, 3'd5, 1'b0});
            check("R11 buf base", op_addr, base);
            check("R11 buf count", op_data, 16'(n));
        end
        // R7 bad final byte
        wr(23'h0, 16'h00E8);
        wr(23'h0, 16'h0001);
        wr(23'h1, 16'h1111);
        wr(23'h2, 16'h2222);
        wr(23'h0, 16'h0070);
        check("R7 buf bad confirm", {op_valid, seq_err}, 2'b01);
        // R12 count out of range
        wr(23'h0, 16'h00E8);
        wr(23'h0, 16'h0010);
        check("R12 count err", {seq_err, buf_wr}, 2'b10);
        wr(23'h0, 16'h1234);
        idle_pulses("R12 closed");
        wr(23'h0, 16'h00E8);
        wr(23'h0, 16'h00FF);
        check("R12 count FF err", seq_err, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule